// File: doc/BRIEF.md
# Reset Cause Controller

This block gathers reset requests from the power-on detector, the external reset pin, the watchdog, the low-voltage detector, a core-issued system request and a brown-out comparator. It turns them into a registered chip-wide reset and a core-only reset. For every source it keeps a sticky cause flag, so software can tell after reboot what brought the chip down. Software can also fire a chip reset or a core-only reset through two self-clearing bits.

The brown-out comparator output is asynchronous. It is brought into the clock domain by a synchronizer before any logic uses it. One mode bit decides what a brown-out does. With the bit set, a low supply forces a chip reset. With the bit clear, a supply crossing in either direction latches a flag that drives an interrupt.

A small register interface exposes four words: the cause flags, the one-shot reset bits, the brown-out control and status, and a 16-bit key that can switch off the power-on source. Writes to the protected fields only take effect while `protWrOk` is high. Reads are combinational on `regAddr`.

Top module: `reset_cause_ctrl`

## Requirements
- R1: After `rstN` is released, `chipRst`, `cpuRst` and `bodIrq` are 0, and all four registers read 0. Register addresses are: 0 cause flags, 1 one-shot bits, 2 brown-out word, 3 power-on key.
- R2: A high level on `pinReq`, `wdtReq`, `lvrReq` or `sysReq` drives `chipRst` and `cpuRst` high one cycle later and sets its cause flag. The flag positions are: pin bit 1, watchdog bit 2, low-voltage bit 3, system request bit 5.
- R3: Writing 1 to a bit of the cause word clears that flag. Writing 0 leaves the flag unchanged. When a source sets a flag in the same cycle that a write clears it, the flag ends up set.
- R4: Writing 1 to bit 0 of word 1 (while protected writes are allowed) raises that bit for exactly two cycles. It drives `chipRst` for two cycles, starting one cycle after the write, and sets cause bit 0. Bit 1 of word 1 does the same for `cpuRst` alone, leaves `chipRst` low, and sets cause bit 7.
- R5: While `protWrOk` is low, writes to the protected fields are ignored. The protected fields are the one-shot bits, the brown-out enable (bit 0) and mode (bit 4) of word 2, and the power-on key.
- R6: Brown-out status (word 2 bit 7) follows `bodCmp` two cycles later while the enable is set. It reads 0 while the enable is clear.
- R7: With both the enable and the mode bit set, a high synchronized comparator drives `chipRst` one cycle later and sets cause bit 4. `bodIrq` stays low in this mode.
- R8: While the enable is set, every change of the synchronized comparator sets the brown-out flag (word 2 bit 5). Writing 1 to that bit clears it. `bodIrq` is the flag gated by enable high and mode low, and it holds until a write to word 2.
- R9: While the power-on key holds 0x5AA5, `porReq` has no effect. Any other key value lets `porReq` reset the chip and set cause bit 0. A reset from any source other than `porReq` clears the key to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset of the controller itself |
| porReq | input | 1 | Power-on detector request |
| pinReq | input | 1 | External reset pin request |
| wdtReq | input | 1 | Watchdog reset request |
| lvrReq | input | 1 | Low-voltage detector request |
| sysReq | input | 1 | Core-issued system reset request |
| bodCmp | input | 1 | Asynchronous brown-out comparator output, high when supply is low |
| protWrOk | input | 1 | Allows writes to protected fields |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` |
| chipRst | output | 1 | Chip-wide reset |
| cpuRst | output | 1 | Core and flash controller reset |
| bodIrq | output | 1 | Brown-out interrupt |

## Verification
Two things can land on the cause word in the same cycle: a software write-one-to-clear and a hardware flag set. The bench provokes this by latching the pin flag first. In one cycle it then writes a clear mask covering both the pin and watchdog bits while `wdtReq` is high. The read-back must show the pin flag gone and the watchdog flag kept. The brown-out flag has the same kind of race. It is judged by checking that the flag persists across writes that carry 0 in its position.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned CAUSE_W = 8;
  localparam int unsigned KEY_W = 16;
  localparam logic [KEY_W-1:0] POR_KEY = 16'h5AA5;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CAUSE = 2'd0,
    ADR_SWRST = 2'd1,
    ADR_BOD   = 2'd2,
    ADR_KEY   = 2'd3
  } rcc_addr_e;

  // cause flag positions
  localparam int unsigned C_POR = 0;
  localparam int unsigned C_PIN = 1;
  localparam int unsigned C_WDT = 2;
  localparam int unsigned C_LVR = 3;
  localparam int unsigned C_BOD = 4;
  localparam int unsigned C_SYS = 5;
  localparam int unsigned C_CPU = 7;

  // brown-out word positions
  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_MODE = 4;
  localparam int unsigned B_FLAG = 5;
  localparam int unsigned B_OUT  = 7;

  typedef struct packed {
    logic causeClr;
    logic swRstWr;
    logic bodCtlWr;
    logic bodFlagClr;
    logic keyWr;
  } rcc_strobe_t;

  typedef struct packed {
    logic [CAUSE_W-1:0] cause;
    logic [1:0]         swBits;
    logic               bodEn;
    logic               bodMode;
    logic               bodFlag;
    logic               bodOut;
    logic [KEY_W-1:0]   porKey;
  } rcc_view_t;
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/rcc_ctrl.sv
module rcc_ctrl
  import rcc_pkg::*;
(
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                wrFlagBit,
  input  logic                protWrOk,
  input  rcc_view_t           view,
  output rcc_strobe_t         strb,
  output logic [DATA_W-1:0]   regRdata
);
  always_comb begin
    strb.causeClr   = regWe && (regAddr == ADR_CAUSE);
    strb.swRstWr    = regWe && (regAddr == ADR_SWRST) && protWrOk;
    strb.bodCtlWr   = regWe && (regAddr == ADR_BOD) && protWrOk;
    strb.bodFlagClr = regWe && (regAddr == ADR_BOD) && wrFlagBit;
    strb.keyWr      = regWe && (regAddr == ADR_KEY) && protWrOk;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADR_CAUSE: regRdata[CAUSE_W-1:0] = view.cause;
      ADR_SWRST: regRdata[1:0] = view.swBits;
      ADR_BOD: begin
        regRdata[B_EN]   = view.bodEn;
        regRdata[B_MODE] = view.bodMode;
        regRdata[B_FLAG] = view.bodFlag;
        regRdata[B_OUT]  = view.bodOut;
      end
      ADR_KEY:   regRdata[KEY_W-1:0] = view.porKey;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/rcc_datapath.sv
module rcc_datapath
  import rcc_pkg::*;
#(
  parameter int unsigned ONESHOT_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  rcc_strobe_t      strb,
  input  logic [KEY_W-1:0] wdata,
  input  logic             porReq,
  input  logic             pinReq,
  input  logic             wdtReq,
  input  logic             lvrReq,
  input  logic             sysReq,
  input  logic             bodSync,
  output rcc_view_t        view,
  output logic             chipRst,
  output logic             cpuRst,
  output logic             bodIrq
);
  localparam int unsigned AGE_W = (ONESHOT_CYC > 1) ? $clog2(ONESHOT_CYC) : 1;

  logic [1:0]         swBits;
  logic [CAUSE_W-1:0] cause, causeSet, clrMask;
  logic               bodEn, bodMode, bodFlag, bodSyncQ;
  logic [KEY_W-1:0]   porKey;
  logic               bodOut, bodReset, porHit, otherHit, chipCause;

  // self-clearing software reset bits
  for (genvar g = 0; g < 2; g++) begin : gOneShot
    logic             bitQ;
    logic [AGE_W-1:0] age;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bitQ <= 1'b0;
        age  <= '0;
      end else if (strb.swRstWr && wdata[g]) begin
        bitQ <= 1'b1;
        age  <= '0;
      end else if (bitQ) begin
        if (age == AGE_W'(ONESHOT_CYC - 1)) bitQ <= 1'b0;
        else                                age  <= age + 1'b1;
      end
    end
    assign swBits[g] = bitQ;
  end

  assign bodOut    = bodEn & bodSync;
  assign bodReset  = bodOut & bodMode;
  assign porHit    = porReq & (porKey != POR_KEY);
  assign otherHit  = pinReq | wdtReq | lvrReq | sysReq | bodReset | swBits[0];
  assign chipCause = porHit | otherHit;

  always_comb begin
    causeSet        = '0;
    causeSet[C_POR] = porHit | swBits[0];
    causeSet[C_PIN] = pinReq;
    causeSet[C_WDT] = wdtReq;
    causeSet[C_LVR] = lvrReq;
    causeSet[C_BOD] = bodReset;
    causeSet[C_SYS] = sysReq;
    causeSet[C_CPU] = swBits[1];
    clrMask         = strb.causeClr ? wdata[CAUSE_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cause    <= '0;
      bodEn    <= 1'b0;
      bodMode  <= 1'b0;
      bodFlag  <= 1'b0;
      bodSyncQ <= 1'b0;
      porKey   <= '0;
      chipRst  <= 1'b0;
      cpuRst   <= 1'b0;
    end else begin
      cause    <= (cause & ~clrMask) | causeSet;
      bodSyncQ <= bodSync;
      if (strb.bodCtlWr) begin
        bodEn   <= wdata[B_EN];
        bodMode <= wdata[B_MODE];
      end
      bodFlag  <= (bodEn & (bodSync ^ bodSyncQ)) | (bodFlag & ~strb.bodFlagClr);
      if (otherHit)        porKey <= '0;
      else if (strb.keyWr) porKey <= wdata;
      chipRst  <= chipCause;
      cpuRst   <= chipCause | swBits[1];
    end
  end

  assign bodIrq = bodFlag & bodEn & ~bodMode;

  always_comb begin
    view.cause   = cause;
    view.swBits  = swBits;
    view.bodEn   = bodEn;
    view.bodMode = bodMode;
    view.bodFlag = bodFlag;
    view.bodOut  = bodOut;
    view.porKey  = porKey;
  end
endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int unsigned ONESHOT_CYC = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porReq,
  input  logic              pinReq,
  input  logic              wdtReq,
  input  logic              lvrReq,
  input  logic              sysReq,
  input  logic              bodCmp,
  input  logic              protWrOk,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              chipRst,
  output logic              cpuRst,
  output logic              bodIrq
);
  rcc_strobe_t strb;
  rcc_view_t   view;
  logic        bodSync;
  logic [1:0]  oneShotBits;
  logic        unusedWdata;

  assign oneShotBits = view.swBits;
  assign unusedWdata = ^regWdata[DATA_W-1:KEY_W];

  rcc_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(bodCmp), .syncOut(bodSync)
  );

  rcc_ctrl uCtrl (
    .regWe(regWe), .regAddr(regAddr), .wrFlagBit(regWdata[B_FLAG]),
    .protWrOk(protWrOk), .view(view), .strb(strb), .regRdata(regRdata)
  );

  rcc_datapath #(.ONESHOT_CYC(ONESHOT_CYC)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(regWdata[KEY_W-1:0]),
    .porReq(porReq), .pinReq(pinReq), .wdtReq(wdtReq), .lvrReq(lvrReq),
    .sysReq(sysReq), .bodSync(bodSync), .view(view),
    .chipRst(chipRst), .cpuRst(cpuRst), .bodIrq(bodIrq)
  );
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker
  import rcc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              pinReq,
  input logic              wdtReq,
  input logic              lvrReq,
  input logic              sysReq,
  input logic              protWrOk,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              chipRst,
  input logic              cpuRst,
  input logic              bodIrq,
  input logic [1:0]        oneShotBits
);
  AST_CHIP_IMPLIES_CPU: assert property (@(posedge clk) disable iff (!rstN)
    chipRst |-> cpuRst); // R2

  AST_SOURCE_RESETS: assert property (@(posedge clk) disable iff (!rstN)
    (pinReq || wdtReq || lvrReq || sysReq) |=> chipRst); // R2

  AST_ONESHOT_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotBits[0] && $past(oneShotBits[0]) &&
     !(regWe && regAddr == ADR_SWRST && protWrOk && regWdata[0])) |=> !oneShotBits[0]); // R4

  AST_PROTECTED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADR_SWRST && !protWrOk && oneShotBits == 2'b00) |=> oneShotBits == 2'b00); // R5

  AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (bodIrq && !(regWe && regAddr == ADR_BOD)) |=> bodIrq); // R8
endmodule

bind reset_cause_ctrl rcc_checker uChk (
  .clk(clk), .rstN(rstN), .pinReq(pinReq), .wdtReq(wdtReq), .lvrReq(lvrReq),
  .sysReq(sysReq), .protWrOk(protWrOk), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .chipRst(chipRst), .cpuRst(cpuRst), .bodIrq(bodIrq),
  .oneShotBits(oneShotBits)
);

// File: tb/sim_reset_cause_ctrl.sv
`timescale 1ns/1ps
module sim_reset_cause_ctrl;
  logic        clk = 1'b0;
  logic        rstN, porReq, pinReq, wdtReq, lvrReq, sysReq, bodCmp, protWrOk, regWe;
  logic [1:0]  regAddr;
  logic [31:0] regWdata, regRdata;
  logic        chipRst, cpuRst, bodIrq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct {
    string       tag;
    int          kind;   // 0 read data, 1 chipRst, 2 cpuRst, 3 bodIrq
    logic [31:0] exp;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  reset_cause_ctrl u0 (
    .clk(clk), .rstN(rstN), .porReq(porReq), .pinReq(pinReq), .wdtReq(wdtReq),
    .lvrReq(lvrReq), .sysReq(sysReq), .bodCmp(bodCmp), .protWrOk(protWrOk),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .chipRst(chipRst), .cpuRst(cpuRst), .bodIrq(bodIrq)
  );

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t       it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = regRdata;
        1:       act = {31'b0, chipRst};
        2:       act = {31'b0, cpuRst};
        default: act = {31'b0, bodIrq};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d: actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expOut(string tag, int kind, logic [31:0] e);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = e;
    sb.push_back(it);
  endtask

  task automatic expReg(string tag, logic [1:0] a, logic [31:0] e);
    regAddr = a;
    expOut(tag, 0, e);
    tick();
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, logic p);
    regWe = 1'b1; regAddr = a; regWdata = d; protWrOk = p;
    tick();
    regWe = 1'b0; regWdata = '0; protWrOk = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 0; porReq = 0; pinReq = 0; wdtReq = 0; lvrReq = 0; sysReq = 0;
    bodCmp = 0; protWrOk = 0; regWe = 0; regAddr = 0; regWdata = 0;
    tick(3);
    rstN = 1;

    // R1 reset state
    expOut("R1", 1, 0); expOut("R1", 2, 0); expOut("R1", 3, 0);
    expReg("R1", 0, 0); expReg("R1", 1, 0); expReg("R1", 2, 0); expReg("R1", 3, 0);

    // R2 each hardware source, then R3 clear
    for (int s = 0; s < 4; s++) begin
      pinReq = (s == 0); wdtReq = (s == 1); lvrReq = (s == 2); sysReq = (s == 3);
      tick();
      pinReq = 0; wdtReq = 0; lvrReq = 0; sysReq = 0;
      expOut("R2", 1, 1); expOut("R2", 2, 1);
      expReg("R2", 0, (s == 0) ? 32'h02 : (s == 1) ? 32'h04 : (s == 2) ? 32'h08 : 32'h20);
      expOut("R2", 1, 0);
      wr(0, 32'hFF, 0);
      expReg("R3", 0, 0);
    end

    // R3 set and clear in the same cycle
    pinReq = 1; tick(); pinReq = 0;
    regWe = 1; regAddr = 0; regWdata = 32'h06; wdtReq = 1;
    tick();
    regWe = 0; regWdata = 0; wdtReq = 0;
    expReg("R3", 0, 32'h04);
    wr(0, 32'h0, 0);
    expReg("R3", 0, 32'h04);
    wr(0, 32'h04, 0);
    expReg("R3", 0, 0);

    // R4 chip one-shot
    wr(1, 32'h1, 1);
    expOut("R4", 1, 0);
    expReg("R4", 1, 32'h1);
    expOut("R4", 1, 1);
    expReg("R4", 1, 32'h1);
    expOut("R4", 1, 1);
    expReg("R4", 1, 32'h0);
    expOut("R4", 1, 0);
    expReg("R4", 0, 32'h01);
    wr(0, 32'hFF, 0);
    // R4 core-only one-shot
    wr(1, 32'h2, 1);
    expReg("R4", 1, 32'h2);
    expOut("R4", 2, 1); expOut("R4", 1, 0);
    expReg("R4", 1, 32'h2);
    expOut("R4", 2, 1);
    expReg("R4", 0, 32'h80);
    expOut("R4", 2, 0);
    wr(0, 32'h80, 0);
    expReg("R4", 0, 0);

    // R5 protected fields ignore unprotected writes
    wr(1, 32'h3, 0);
    expReg("R5", 1, 0);
    expOut("R5", 1, 0);
    wr(2, 32'h11, 0);
    expReg("R5", 2, 0);
    wr(3, 32'h5AA5, 0);
    expReg("R5", 3, 0);

    // R6 / R8 interrupt mode
    wr(2, 32'h01, 1);
    bodCmp = 1;
    tick();
    expReg("R6", 2, 32'h01);
    expReg("R6", 2, 32'h81);
    expOut("R8", 3, 1); expOut("R8", 1, 0);
    expReg("R8", 2, 32'hA1);
    wr(2, 32'h00, 1);
    expOut("R6", 3, 0);
    expReg("R6", 2, 32'h20);
    wr(2, 32'h20, 0);
    expReg("R8", 2, 0);
    wr(2, 32'h01, 1);
    expReg("R8", 2, 32'h81);
    bodCmp = 0;
    tick(3);
    expOut("R8", 3, 1);
    expReg("R8", 2, 32'h21);
    wr(2, 32'h21, 0);
    expOut("R8", 3, 0);
    expReg("R8", 2, 32'h01);
    wr(2, 32'h00, 1);

    // R7 reset mode
    wr(2, 32'h11, 1);
    bodCmp = 1;
    tick(3);
    expOut("R7", 1, 1); expOut("R7", 3, 0);
    expReg("R7", 0, 32'h10);
    bodCmp = 0;
    tick(4);
    expOut("R7", 1, 0);
    expReg("R7", 2, 32'h31);
    wr(0, 32'h10, 0);
    wr(2, 32'h20, 1);
    expReg("R7", 2, 0);
    expReg("R7", 0, 0);

    // R9 power-on key
    wr(3, 32'h5AA5, 1);
    expReg("R9", 3, 32'h5AA5);
    porReq = 1; tick(); porReq = 0;
    expOut("R9", 1, 0);
    expReg("R9", 0, 0);
    wr(3, 32'h1234, 1);
    porReq = 1; tick(); porReq = 0;
    expOut("R9", 1, 1);
    expReg("R9", 0, 32'h01);
    wr(0, 32'h01, 0);
    wr(3, 32'h5AA5, 1);
    wdtReq = 1; tick(); wdtReq = 0;
    expOut("R9", 1, 1);
    expReg("R9", 3, 0);
    expReg("R9", 0, 32'h04);
    wr(0, 32'hFF, 0);

    @(negedge clk);
    #1;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule